// File: doc/BRIEF.md
# Metastability-Corrected Coarse Time Counter

This block gives an asynchronous hit a coarse timestamp counted in system clock cycles. A free-running binary counter advances on every system clock edge. The counter is never sampled by the hit itself. The hit first passes through a two-register synchroniser. An AND of the first stage with the inverted second stage then forms a one-cycle strobe in the system clock domain, and that strobe loads the count into a holding register.

A separate register is clocked by the hit's own rising edge. It records the level of the system clock at the moment the hit arrived, which shows whether the hit fell in the high phase or the low phase of the cycle. That bit is passed through two system clock registers before it is used. The reported coarse time is the held count plus this check bit. The sum is one bit wider than the counter, so a result that crosses the counter's top value keeps its carry.

A hit must stay high until the result appears, and it must stay low for at least two system clock cycles before the next hit. Fine interpolation and result buffering are handled elsewhere.

Top module: `mct_coarse_stamp`

## Requirements
- R1: After reset is released, the counter starts at 0 and increases by one on every system clock rising edge. It wraps from 2^CNT_W-1 to 0.
- R2: Let v be the counter value during the cycle in which hit_i rises. The held count is (v+1) mod 2^CNT_W, which is the value the counter has in the cycle after the first synchroniser stage captures the hit.
- R3: The check bit is 1 when hit_i rises while clk_i is high, and 0 when hit_i rises while clk_i is low.
- R4: One rising edge of hit_i yields exactly one result. coarse_valid_o is high for a single cycle, and it goes high after the third system clock rising edge that follows the hit. Keeping hit_i high for longer yields no further results.
- R5: coarse_time_o, which is CNT_W+1 bits wide, equals the zero-extended held count plus the check bit, with the carry kept. When the held count is 2^CNT_W-1 and the check bit is 1, the result is exactly 2^CNT_W.
- R6: Between results coarse_valid_o stays low, and coarse_time_o keeps the last result unchanged.
- R7: While rst_n is low, coarse_valid_o is 0 and coarse_time_o is 0.
- R8: A hit that arrives in the cycle where the counter holds 2^CNT_W-1 produces a held count of 0. With a low-phase arrival the result is therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Asynchronous hit; its rising edge is time-stamped |
| coarse_time_o | output | CNT_W+1 | Held count plus check bit, carry kept |
| coarse_valid_o | output | 1 | One-cycle strobe marking a new coarse_time_o |

## Verification
The bench builds the block with CNT_W set to 6. The counter then wraps every 64 cycles, so hits can be placed on both sides of the wrap: on the top count, where the carry case gives 64, and on the count just before zero. The bench tracks its own cycle count from reset release. It places each hit edge either 1 ns or 6 ns after a rising edge, so both check-bit values are exercised, and it also holds one hit high for many cycles to confirm that only a single result appears.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int unsigned MCT_CNT_W_DEFAULT = 16;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } hit_phase_e;

endpackage

// File: rtl/mct_free_counter.sv
module mct_free_counter #(
    parameter int unsigned CNT_W = mct_pkg::MCT_CNT_W_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    AST_CNT_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(rst_n) |-> count_o == CNT_W'($past(count_o) + 1'b1)); // R1

endmodule

// File: rtl/mct_hit_sync.sv
module mct_hit_sync (
    input  logic clk_i,
    input  logic rst_n,
    input  logic hit_i,
    output logic strobe_o
);

    typedef struct packed {
        logic stage1;
        logic stage2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = hit_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.stage1 & ~st_q.stage2;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R4

endmodule

// File: rtl/mct_check_capture.sv
module mct_check_capture (
    input  logic clk_i,
    input  logic rst_n,
    input  logic hit_i,
    output logic check_o
);

    import mct_pkg::*;

    hit_phase_e phase_raw_q;

    always_ff @(posedge hit_i or negedge rst_n) begin
        if (!rst_n) begin
            phase_raw_q <= PH_LOW;
        end else begin
            phase_raw_q <= hit_phase_e'(clk_i);
        end
    end

    typedef struct packed {
        logic meta;
        logic safe;
    } chk_state_t;

    chk_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = (phase_raw_q == PH_HIGH);
        st_d.safe = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign check_o = st_q.safe;

endmodule

// File: rtl/mct_coarse_stamp.sv
module mct_coarse_stamp #(
    parameter int unsigned CNT_W = mct_pkg::MCT_CNT_W_DEFAULT
) (
    input  logic           clk_i,
    input  logic           rst_n,
    input  logic           hit_i,
    output logic [CNT_W:0] coarse_time_o,
    output logic           coarse_valid_o
);

    localparam logic [CNT_W:0] SUM_MAX = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W-1:0] count;
    logic             strobe;
    logic             check;

    mct_free_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .count_o (count)
    );

    mct_hit_sync u_sync (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .hit_i    (hit_i),
        .strobe_o (strobe)
    );

    mct_check_capture u_check (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .hit_i   (hit_i),
        .check_o (check)
    );

    typedef struct packed {
        logic [CNT_W-1:0] held;
        logic             pending;
        logic [CNT_W:0]   result;
        logic             valid;
    } top_state_t;

    top_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.pending = 1'b0;
        if (strobe) begin
            st_d.held    = count;
            st_d.pending = 1'b1;
        end
        if (st_q.pending) begin
            st_d.result = {1'b0, st_q.held} + {{CNT_W{1'b0}}, check};
            st_d.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coarse_time_o  = st_q.result;
    assign coarse_valid_o = st_q.valid;

    AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
        coarse_valid_o |=> !coarse_valid_o); // R4
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
        !coarse_valid_o |-> $stable(coarse_time_o)); // R6
    AST_SUM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
        coarse_valid_o |-> coarse_time_o <= SUM_MAX); // R5
    AST_STROBE_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
        strobe |=> ##1 coarse_valid_o); // R4

endmodule

// File: tb/mct_coarse_stamp_tb.sv
module mct_coarse_stamp_tb;

    localparam int unsigned W    = 6;
    localparam int unsigned MODV = 1 << W;

    logic         clk;
    logic         rst_n;
    logic         hit;
    logic [W:0]   coarse;
    logic         valid;
    int unsigned  ref_cnt;
    int           total;
    int           bad;
    bit           done;

    mct_coarse_stamp #(.CNT_W(W)) u_dut (
        .clk_i          (clk),
        .rst_n          (rst_n),
        .hit_i          (hit),
        .coarse_time_o  (coarse),
        .coarse_valid_o (valid)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ref_cnt <= 0;
        else        ref_cnt <= ref_cnt + 1;
    end

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One hit: high_phase picks a 1 ns or 6 ns offset after a rising edge.
    task automatic hit_once(input bit high_phase, input string req);
        int unsigned v;
        int          exp_val;
        @(posedge clk);
        if (high_phase) #1; else #6;
        hit = 1'b1;
        v = ref_cnt;
        exp_val = int'((v + 1) % MODV) + (high_phase ? 1 : 0);
        @(posedge clk);
        @(posedge clk);
        #4;
        check({req, " R4 no early valid"}, int'(valid), 0);
        @(posedge clk);
        #4;
        check({req, " R4 valid"}, int'(valid), 1);
        check({req, " R2 R3 R5 value"}, int'(coarse), exp_val);
        hit = 1'b0;
        @(posedge clk);
        #4;
        check({req, " R4 valid drops"}, int'(valid), 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset;
        #4;
        check("R7 valid in reset", int'(valid), 0);
        check("R7 time in reset", int'(coarse), 0);
    endtask

    task automatic t_phases;
        hit_once(1'b1, "high phase");
        hit_once(1'b0, "low phase");
        repeat (5) @(posedge clk);
        hit_once(1'b1, "high phase later R1");
        repeat (11) @(posedge clk);
        hit_once(1'b0, "low phase later R1");
    endtask

    task automatic t_long_hit;
        int n_valid = 0;
        @(posedge clk);
        #1;
        hit = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            #4;
            if (valid) n_valid++;
        end
        hit = 1'b0;
        repeat (3) @(posedge clk);
        check("R4 one result for long hit", n_valid, 1);
    endtask

    task automatic t_hold;
        logic [W:0] last;
        int changes = 0;
        int valids  = 0;
        hit_once(1'b1, "hold setup");
        last = coarse;
        for (int i = 0; i < 15; i++) begin
            @(posedge clk);
            #4;
            if (coarse != last) changes++;
            if (valid) valids++;
        end
        check("R6 time unchanged between hits", changes, 0);
        check("R6 valid low between hits", valids, 0);
    endtask

    task automatic t_wrap_carry;
        // The hit lands in the cycle where the counter holds MODV-2, so the held count is MODV-1 (R5).
        while ((ref_cnt % MODV) != MODV - 3) begin
            @(posedge clk);
            #1;
        end
        hit_once(1'b1, "R5 carry");
    endtask

    task automatic t_wrap_zero;
        // The hit lands in the cycle where the counter holds MODV-1 (R8).
        while ((ref_cnt % MODV) != MODV - 2) begin
            @(posedge clk);
            #1;
        end
        hit_once(1'b0, "R8 wrap to zero");
    endtask

    initial begin
        total = 0;
        bad   = 0;
        done  = 1'b0;
        hit   = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_phases();
        t_long_hit();
        t_hold();
        t_wrap_carry();
        t_wrap_zero();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule